// File: doc/BRIEF.md
# Local interrupt controller countdown timer

This block is the countdown timer of a per-processor local interrupt controller. Software programs it through a small register port. An initial count starts a run. A divide setting selects how many time-base units make one timer tick, from 1 to 128 in powers of two. A timer vector entry carries an 8-bit vector, a mask bit and a periodic/one-shot bit. The block takes a free-running time base from outside. It measures the ticks elapsed since the count was loaded and raises a one-cycle expiry pulse tagged with the programmed vector.

All scheduling is relative to the time-base value captured when the count was written. One period is the initial count plus one ticks long. A periodic run fires at every whole multiple of that period. A one-shot run fires once at the first multiple and then goes idle. A zero count arms nothing. The block also shows whether an expiry is pending and, if so, the absolute time-base value at which it will occur. Software can read back a live current-count value.

Top module: `local_irq_timer`

## Requirements
- R1: After reset, `pending` is 0 and `next_expiry` is all ones. Reading address 0 (timer entry) returns 0x0001_0000: mask bit 16 set, periodic bit 17 clear, vector bits [7:0] zero. Addresses 1 (initial count), 2 (divide) and 3 (current count) read 0.
- R2: In one-shot mode (entry bit 17 = 0), a count C >= 1 written at time-base value L with shift s gives exactly one pulse. The pulse is high in the cycle after the clock edge at which `time_base` equals L + ((C+1) << s). After that pulse `pending` is 0 and `next_expiry` is all ones.
- R3: In periodic mode (entry bit 17 = 1), pulses follow the clock edges at which `time_base` equals L + ((k*(C+1)) << s) for k = 1, 2, 3 and onward. Each pulse lasts a single cycle.
- R4: Writing an initial count of 0 arms nothing in either mode. No pulse follows and `pending` stays 0.
- R5: While the mask bit (entry bit 16) is set, no pulse is produced, `pending` is 0 and `next_expiry` is all ones. A periodic schedule keeps counting while masked, so clearing the mask resumes pulses on the original grid, skipping the slots that passed while masked.
- R6: While `pending` is 1, `next_expiry` equals L plus the tick count of the next expiry shifted left by s.
- R7: The divide register (address 2, bits [2:0]) holds the shift s. The shift and the periodic bit are sampled only when a count is written, so a later change to either leaves the running schedule unchanged.
- R8: Writing the initial count (address 1) captures the present `time_base` as the new L and discards any earlier schedule.
- R9: Each pulse carries on `expire_vec` the entry's bits [7:0] as they stood when the expiry occurred.
- R10: Reading address 3 returns C minus the ticks elapsed within the current period while a run is scheduled. It returns 0 when nothing is scheduled, including after a one-shot expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| time_base | input | 32 | Free-running time-base value |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 entry, 1 count, 2 divide, 3 current count) |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| expire_pulse | output | 1 | One-cycle expiry pulse |
| expire_vec | output | 8 | Vector carried with the pulse |
| pending | output | 1 | An unmasked expiry is scheduled |
| next_expiry | output | 32 | Absolute time of the next expiry, all ones if none |

## Verification
The assertions rely on three assumptions about the inputs. The time base advances by at most one per clock. The time base never wraps within a run. At most one register write occurs per cycle. Under these assumptions a scaled period of at least two ticks can never produce back-to-back pulses. The bench drives a time base that increments by exactly one each clock from zero, issues writes one at a time through a single task, and keeps every run far shorter than the 32-bit time range.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
    typedef enum logic [1:0] {
        REG_ENTRY = 2'd0,
        REG_INIT  = 2'd1,
        REG_DIV   = 2'd2,
        REG_CUR   = 2'd3
    } reg_addr_e;

    localparam int ENTRY_MASK_BIT = 16;
    localparam int ENTRY_PER_BIT  = 17;
endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8,
    parameter int SHW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [VEC_W-1:0]  vec_o,
    output logic              mask_o,
    output logic              per_o,
    output logic [SHW-1:0]    shift_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_cnt_o
);
    import ltmr_pkg::*;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             mask;
        logic             per;
        logic [SHW-1:0]   div;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;
    reg_addr_e sel;

    assign sel = reg_addr_e'(addr);

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                REG_ENTRY: begin
                    r_d.vec  = wdata[VEC_W-1:0];
                    r_d.mask = wdata[ENTRY_MASK_BIT];
                    r_d.per  = wdata[ENTRY_PER_BIT];
                end
                REG_INIT: r_d.cnt = wdata[CNT_W-1:0];
                REG_DIV:  r_d.div = wdata[SHW-1:0];
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_ENTRY: begin
                rdata[VEC_W-1:0]      = r_q.vec;
                rdata[ENTRY_MASK_BIT] = r_q.mask;
                rdata[ENTRY_PER_BIT]  = r_q.per;
            end
            REG_INIT: rdata[CNT_W-1:0] = r_q.cnt;
            REG_DIV:  rdata[SHW-1:0]   = r_q.div;
            default:  rdata[CNT_W-1:0] = cur_cnt;
        endcase
    end

    assign vec_o      = r_q.vec;
    assign mask_o     = r_q.mask;
    assign per_o      = r_q.per;
    assign shift_o    = r_q.div;
    assign load_o     = wr_en && (sel == REG_INIT);
    assign load_cnt_o = wdata[CNT_W-1:0];
endmodule

// File: rtl/ltmr_sched.sv
module ltmr_sched #(
    parameter int TB_W  = 32,
    parameter int CNT_W = 32,
    parameter int VEC_W = 8,
    parameter int SHW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  time_base,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_cnt_i,
    input  logic [SHW-1:0]   shift_i,
    input  logic             per_i,
    input  logic             mask_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             pulse_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             pending_o,
    output logic [TB_W-1:0]  expiry_o,
    output logic [CNT_W-1:0] cur_o
);
    typedef struct packed {
        logic [TB_W-1:0]  load_t;
        logic [SHW-1:0]   shift;
        logic             per;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [TB_W-1:0]  next_tick;
        logic             pulse;
        logic [VEC_W-1:0] vec;
    } sched_t;

    sched_t s_d, s_q;
    logic [TB_W-1:0] elapsed;
    logic [TB_W-1:0] period;
    logic            fire;

    assign elapsed = (time_base - s_q.load_t) >> s_q.shift;
    assign period  = TB_W'(s_q.cnt) + TB_W'(1);
    assign fire    = s_q.armed && (elapsed >= s_q.next_tick);

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (load_i) begin
            s_d.load_t    = time_base;
            s_d.shift     = shift_i;
            s_d.per       = per_i;
            s_d.cnt       = load_cnt_i;
            s_d.armed     = (load_cnt_i != '0);
            s_d.next_tick = TB_W'(load_cnt_i) + TB_W'(1);
        end else if (fire) begin
            s_d.pulse = !mask_i;
            s_d.vec   = vec_i;
            if (s_q.per) begin
                s_d.next_tick = s_q.next_tick + period;
            end else begin
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse_o   = s_q.pulse;
    assign vec_o     = s_q.vec;
    assign pending_o = s_q.armed && !mask_i;
    assign expiry_o  = pending_o ? (s_q.load_t + (s_q.next_tick << s_q.shift)) : '1;
    assign cur_o     = (!s_q.armed || elapsed >= s_q.next_tick) ? '0
                     : CNT_W'(s_q.next_tick - elapsed - TB_W'(1));

    assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> !pulse_o);
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    assert_oneshot_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !s_q.per) |-> (!pending_o && expiry_o == '1));
    assert_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_cnt_i == '0) |=> !pending_o);
    assert_load_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_cnt_i != '0 && !mask_i) |=>
        (pending_o && expiry_o == $past(time_base) +
            ((TB_W'($past(load_cnt_i)) + TB_W'(1)) << $past(shift_i))));
    assert_cur_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_o <= s_q.cnt);
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer #(
    parameter int TB_W   = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8,
    parameter int SHW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TB_W-1:0]   time_base,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              expire_pulse,
    output logic [VEC_W-1:0]  expire_vec,
    output logic              pending,
    output logic [TB_W-1:0]   next_expiry
);
    logic [VEC_W-1:0] vec;
    logic             mask;
    logic             per;
    logic [SHW-1:0]   shift;
    logic             load;
    logic [CNT_W-1:0] load_cnt;
    logic [CNT_W-1:0] cur_cnt;

    ltmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .SHW(SHW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cur_cnt(cur_cnt), .rdata(rdata), .vec_o(vec), .mask_o(mask),
        .per_o(per), .shift_o(shift), .load_o(load), .load_cnt_o(load_cnt)
    );

    ltmr_sched #(.TB_W(TB_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .SHW(SHW)) u_sched (
        .clk(clk), .rst_n(rst_n), .time_base(time_base), .load_i(load),
        .load_cnt_i(load_cnt), .shift_i(shift), .per_i(per), .mask_i(mask),
        .vec_i(vec), .pulse_o(expire_pulse), .vec_o(expire_vec),
        .pending_o(pending), .expiry_o(next_expiry), .cur_o(cur_cnt)
    );
endmodule

// File: tb/sim_local_irq_timer.sv
`timescale 1ns/100ps
module sim_local_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] time_base = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        expire_pulse;
    logic [7:0]  expire_vec;
    logic        pending;
    logic [31:0] next_expiry;

    typedef struct { logic [31:0] t; logic [7:0] v; } item_t;
    item_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    local_irq_timer u0 (.clk(clk), .rst_n(rst_n), .time_base(time_base),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .expire_pulse(expire_pulse), .expire_vec(expire_vec),
        .pending(pending), .next_expiry(next_expiry));

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            time_base <= time_base + 32'd1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // monitor: pops expected pulses
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && expire_pulse) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2/R3/R4/R5 unexpected pulse", {32'd0, time_base}, 64'd0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(time_base == it.t, "R3 pulse time", time_base, it.t);
                    check(expire_vec == it.v, "R9 pulse vector", expire_vec, it.v);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic [31:0] stamp);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        stamp = time_base;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic push(input logic [31:0] t, input logic [7:0] v);
        item_t it;
        it.t = t; it.v = v;
        exp_q.push_back(it);
    endtask

    task automatic drain(input int max_cyc, input string tag);
        for (int i = 0; i < max_cyc && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // current-count check against model, avoiding the fire-boundary tick
    task automatic check_cur(input logic [31:0] L, input int s, input int c, input bit per, input string tag);
        logic [31:0] d, el, expv;
        for (int tries = 0; tries < 4; tries++) begin
            rd(2'd3, d);
            el = (time_base - L) >> s;
            if (!(per && el != 0 && (el % (c + 1)) == 0)) break;
        end
        if (per) expv = c - (el % (c + 1));
        else     expv = (el < c) ? c - el : 0;
        check(d == expv, tag, d, expv);
    endtask

    initial begin
        logic [31:0] L, U, d, t;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(pending == 1'b0, "R1 pending after reset", pending, 0);
        check(next_expiry == 32'hFFFF_FFFF, "R1 expiry marker", next_expiry, 32'hFFFF_FFFF);
        rd(2'd0, d); check(d == 32'h0001_0000, "R1 entry reset", d, 32'h0001_0000);
        rd(2'd1, d); check(d == 0, "R1 count reset", d, 0);
        rd(2'd2, d); check(d == 0, "R1 divide reset", d, 0);
        rd(2'd3, d); check(d == 0, "R1 current reset", d, 0);

        // one-shot, shift 0
        wr(2'd0, 32'h0000_0031, U);
        wr(2'd1, 32'd5, L);
        push(L + 32'd6, 8'h31);
        check(pending == 1'b1, "R6 pending after load", pending, 1);
        check(next_expiry == L + 32'd6, "R6 expiry one-shot", next_expiry, L + 32'd6);
        check_cur(L, 0, 5, 0, "R10 current one-shot");
        drain(40, "R2 one-shot pulse seen");
        idle(2);
        check(pending == 1'b0, "R2 pending cleared", pending, 0);
        check(next_expiry == 32'hFFFF_FFFF, "R2 marker after fire", next_expiry, 32'hFFFF_FFFF);
        rd(2'd3, d); check(d == 0, "R10 current after one-shot", d, 0);
        idle(30);

        // periodic, divide by 4
        wr(2'd0, 32'h0002_0077, U);
        wr(2'd2, 32'd2, U);
        rd(2'd2, d); check(d == 2, "R7 divide readback", d, 2);
        wr(2'd1, 32'd3, L);
        for (int i = 1; i <= 3; i++) push(L + (32'(i) * 32'd16), 8'h77);
        check(next_expiry == L + 32'd16, "R6 expiry periodic", next_expiry, L + 32'd16);
        idle(5);
        check_cur(L, 2, 3, 1, "R10 current periodic");
        idle(14);
        check_cur(L, 2, 3, 1, "R10 current periodic second period");
        drain(80, "R3 periodic pulses seen");
        wr(2'd1, 32'd0, L);
        idle(1);
        check(pending == 1'b0, "R4 periodic zero count", pending, 0);
        idle(40);

        // one-shot zero count
        wr(2'd0, 32'h0000_0012, U);
        wr(2'd2, 32'd0, U);
        wr(2'd1, 32'd0, L);
        check(pending == 1'b0, "R4 one-shot zero count", pending, 0);
        idle(30);

        // masked periodic, then unmask
        wr(2'd0, 32'h0003_0044, U);
        wr(2'd1, 32'd4, L);
        check(pending == 1'b0, "R5 pending masked", pending, 0);
        check(next_expiry == 32'hFFFF_FFFF, "R5 marker masked", next_expiry, 32'hFFFF_FFFF);
        idle(21);
        wr(2'd0, 32'h0002_0044, U);
        k = 1;
        while (L + 32'(k * 5) <= U) k++;
        for (int i = 0; i < 3; i++) push(L + 32'((k + i) * 5), 8'h44);
        drain(40, "R5 pulses after unmask");
        wr(2'd1, 32'd0, L);
        idle(20);

        // divide and mode changes after load are deferred
        wr(2'd0, 32'h0000_005A, U);
        wr(2'd1, 32'd7, L);
        push(L + 32'd8, 8'h5A);
        wr(2'd2, 32'd3, U);
        wr(2'd0, 32'h0002_005A, U);
        check(next_expiry == L + 32'd8, "R7 expiry unchanged by divide", next_expiry, L + 32'd8);
        drain(40, "R7 one-shot pulse kept");
        idle(60);
        check(pending == 1'b0, "R7 stayed one-shot", pending, 0);

        // reload restarts
        wr(2'd0, 32'h0000_0066, U);
        wr(2'd2, 32'd0, U);
        wr(2'd1, 32'd20, t);
        idle(5);
        wr(2'd1, 32'd4, L);
        push(L + 32'd5, 8'h66);
        check(next_expiry == L + 32'd5, "R8 expiry from reload", next_expiry, L + 32'd5);
        drain(40, "R8 reload pulse");
        idle(40);
        check(exp_q.size() == 0 && pending == 1'b0, "R8 old schedule gone", pending, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule